// File: doc/BRIEF.md
# Calibration code-transition detector

This block sits behind a 14-bit offset-binary converter that is sampling continuously with a fixed calibration voltage on its input. It runs only after warm-up. Over a window of valid samples it counts how often each of two adjacent target codes appears, and how often any other code appears. It then reports whether the reading sits on the chosen code boundary. The trim is correct when the two target codes occur about equally often.

There are two calibration points. The offset point is the step from mid-scale (MSB set, all other bits clear) to mid-scale plus one, which ideally lies at +1/2 LSB. The gain point is the step from all-ones minus one to all-ones, which ideally lies at full scale minus 1 1/2 LSB. Offset has to be settled before gain, so a gain window is refused until the most recent finished offset window was balanced. An operator or controller repeats windows while turning the trim, and reads the counts, the balanced flag and the direction hint.

Top module: `cal_xover_mon`

## Requirements
- R1: After reset, all three counts are 0, `done_o`, `balanced_o` and `offset_ok_o` are 0, and `dir_o` is 0 (no result).
- R2: In offset mode (`gain_mode_i`=0), the low target is code 0x2000 and the high target is 0x2001. Each counted sample equal to one of them increments `lo_cnt_o` or `hi_cnt_o`.
- R3: In gain mode (`gain_mode_i`=1), the low target is 0x3FFE and the high target is 0x3FFF. In either mode, any other code increments `out_cnt_o`.
- R4: A window counts only cycles with `valid_i`=1 after the start cycle. A sample presented in the same cycle as an accepted start is not counted. The window ends at the `win_len_i`-th counted sample, and a length of 0 behaves as 1.
- R5: `done_o` is 1 for exactly one cycle: the cycle after the clock edge that registers the last sample of the window.
- R6: An accepted `start_i` clears all counts and the result in the next cycle, and restarts the window even if one is in progress. Counts and result otherwise hold their values until the next accepted start.
- R7: With a result present, `balanced_o` is 1 exactly when `out_cnt_o` is 0 and |lo−hi| ≤ the `tol_i` value latched at start.
- R8: `dir_o` encoding with a result present. If out>0: 5 when more samples lay above the high target than below the low target, otherwise 4. If out=0: 1 when lo=hi, 2 when lo>hi, 3 when hi>lo. With no result present, `dir_o` is 0.
- R9: A start in gain mode is ignored while `offset_ok_o`=0 and changes no state. `offset_ok_o` takes the `balanced_o` value of each finished offset window, one cycle after its `done_o`.

Each accepted start also latches the mode, the window length and the tolerance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 14 | Converter output code, offset binary |
| valid_i | input | 1 | `sample_i` holds a new conversion |
| gain_mode_i | input | 1 | 0 = offset point, 1 = gain point; sampled at start |
| win_len_i | input | 16 | Window length in valid samples; sampled at start |
| tol_i | input | 16 | Allowed lo/hi count difference; sampled at start |
| start_i | input | 1 | Begin a new window |
| lo_cnt_o | output | 16 | Count of the low target code |
| hi_cnt_o | output | 16 | Count of the high target code |
| out_cnt_o | output | 16 | Count of all other codes |
| balanced_o | output | 1 | Result shows the trim is on the boundary |
| dir_o | output | 3 | Direction hint, encoding per R8 |
| done_o | output | 1 | One-cycle end-of-window pulse |
| offset_ok_o | output | 1 | Offset point qualified; gain windows allowed |

## Verification
Some behaviours are checked by assertions on every cycle:
- `done_o` never lasts two cycles.
- A refused gain start leaves the sequencer unchanged.
- The counters are zero after every accepted start.
- A balanced result never coexists with out-of-pair samples or with an outside direction.
- At every end of window, the three counts add up to the latched window length.
- `offset_ok_o` only rises right after a done pulse.

Other behaviours only the directed scenarios can show:
- Which exact codes fall into which bin in each mode.
- Whether the direction picks the correct side of the pair.
- The tolerance boundary, where a difference equal to the tolerance is still balanced.
- Revocation of the qualification after a failed offset window.
- That a sample arriving with the start command is dropped.

// File: rtl/cal_xover_pkg.sv
package cal_xover_pkg;
  typedef enum logic [1:0] {
    BIN_LO    = 2'd0,
    BIN_HI    = 2'd1,
    BIN_BELOW = 2'd2,
    BIN_ABOVE = 2'd3
  } bin_e;

  typedef enum logic [2:0] {
    DIR_NONE  = 3'd0,
    DIR_EVEN  = 3'd1,
    DIR_LOW   = 3'd2,
    DIR_HIGH  = 3'd3,
    DIR_BELOW = 3'd4,
    DIR_ABOVE = 3'd5
  } dir_e;

  localparam int NUM_BINS = 4;
endpackage

// File: rtl/cal_xover_classify.sv
module cal_xover_classify
  import cal_xover_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic [DATA_W-1:0] code_i,
  input  logic              gain_i,
  output bin_e              bin_o
);
  localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] TOP_LO   = {{(DATA_W-1){1'b1}}, 1'b0};
  localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);

  logic [DATA_W-1:0] lo_code, hi_code;

  always_comb begin
    lo_code = gain_i ? TOP_LO : MID_CODE;
    hi_code = lo_code + ONE;
    if (code_i == lo_code)      bin_o = BIN_LO;
    else if (code_i == hi_code) bin_o = BIN_HI;
    else if (code_i < lo_code)  bin_o = BIN_BELOW;
    else                        bin_o = BIN_ABOVE;
  end
endmodule

// File: rtl/cal_xover_tally.sv
module cal_xover_tally
  import cal_xover_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               clr_i,
  input  logic                               inc_i,
  input  bin_e                               bin_i,
  output logic [NUM_BINS-1:0][CNT_W-1:0]     cnt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               cnt_o[b] <= '0;
      else if (clr_i)                            cnt_o[b] <= '0;
      else if (inc_i && (int'(bin_i) == b))      cnt_o[b] <= cnt_o[b] + ONE;
    end
  end

  // R6: counters are empty after a clear
  a_r6_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/cal_xover_judge.sv
module cal_xover_judge
  import cal_xover_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [NUM_BINS-1:0][CNT_W-1:0]     cnt_i,
  input  logic                               res_vld_i,
  input  logic [CNT_W-1:0]                   tol_i,
  output logic                               balanced_o,
  output dir_e                               dir_o
);
  logic [CNT_W-1:0] lo, hi, below, above, diff;
  logic             out_any;

  always_comb begin
    lo      = cnt_i[BIN_LO];
    hi      = cnt_i[BIN_HI];
    below   = cnt_i[BIN_BELOW];
    above   = cnt_i[BIN_ABOVE];
    out_any = (below != '0) || (above != '0);
    diff    = (lo >= hi) ? (lo - hi) : (hi - lo);
    balanced_o = res_vld_i && !out_any && (diff <= tol_i);
    if (!res_vld_i)    dir_o = DIR_NONE;
    else if (out_any)  dir_o = (above > below) ? DIR_ABOVE : DIR_BELOW;
    else if (lo > hi)  dir_o = DIR_LOW;
    else if (hi > lo)  dir_o = DIR_HIGH;
    else               dir_o = DIR_EVEN;
  end

  // R7/R8: a balanced verdict never carries an outside direction
  a_r7_balanced_inside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    balanced_o |-> (dir_o inside {DIR_EVEN, DIR_LOW, DIR_HIGH}));
endmodule

// File: rtl/cal_xover_ctrl.sv
module cal_xover_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             gain_mode_i,
  input  logic [CNT_W-1:0] win_len_i,
  input  logic [CNT_W-1:0] tol_i,
  input  logic             valid_i,
  input  logic             balanced_i,
  output logic             clr_o,
  output logic             take_o,
  output logic             gain_o,
  output logic [CNT_W-1:0] tol_o,
  output logic [CNT_W-1:0] len_o,
  output logic             res_vld_o,
  output logic             done_o,
  output logic             offset_ok_o
);
  localparam logic [CNT_W:0]   ONE_W = (CNT_W+1)'(1);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic             running_q;
  logic [CNT_W-1:0] seen_q;
  logic             last;

  assign clr_o  = start_i && (!gain_mode_i || offset_ok_o);
  assign take_o = running_q && valid_i && !clr_o;
  assign last   = take_o && (({1'b0, seen_q} + ONE_W) >= {1'b0, len_o});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      seen_q    <= '0;
      gain_o    <= 1'b0;
      len_o     <= '0;
      tol_o     <= '0;
      res_vld_o <= 1'b0;
      done_o    <= 1'b0;
    end else if (clr_o) begin
      running_q <= 1'b1;
      seen_q    <= '0;
      gain_o    <= gain_mode_i;
      len_o     <= win_len_i;
      tol_o     <= tol_i;
      res_vld_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= last;
      if (take_o) seen_q <= seen_q + ONE;
      if (last) begin
        running_q <= 1'b0;
        res_vld_o <= 1'b1;
      end
    end
  end

  // verdict of each finished offset window requalifies or revokes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 offset_ok_o <= 1'b0;
    else if (done_o && !gain_o)  offset_ok_o <= balanced_i;
  end

  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_refused_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && gain_mode_i && !offset_ok_o) |=>
      (running_q == $past(running_q)) && (gain_o == $past(gain_o)) && (len_o == $past(len_o)));

  a_r9_qualify_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(offset_ok_o) |-> $past(done_o));
endmodule

// File: rtl/cal_xover_mon.sv
module cal_xover_mon
  import cal_xover_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              valid_i,
  input  logic              gain_mode_i,
  input  logic [CNT_W-1:0]  win_len_i,
  input  logic [CNT_W-1:0]  tol_i,
  input  logic              start_i,
  output logic [CNT_W-1:0]  lo_cnt_o,
  output logic [CNT_W-1:0]  hi_cnt_o,
  output logic [CNT_W-1:0]  out_cnt_o,
  output logic              balanced_o,
  output logic [2:0]        dir_o,
  output logic              done_o,
  output logic              offset_ok_o
);
  logic                           clr, take, gain_q, res_vld;
  logic [CNT_W-1:0]               tol_q, len_q;
  logic [NUM_BINS-1:0][CNT_W-1:0] cnt;
  bin_e                           bin;
  dir_e                           dir;

  cal_xover_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .gain_mode_i (gain_mode_i),
    .win_len_i   (win_len_i),
    .tol_i       (tol_i),
    .valid_i     (valid_i),
    .balanced_i  (balanced_o),
    .clr_o       (clr),
    .take_o      (take),
    .gain_o      (gain_q),
    .tol_o       (tol_q),
    .len_o       (len_q),
    .res_vld_o   (res_vld),
    .done_o      (done_o),
    .offset_ok_o (offset_ok_o)
  );

  cal_xover_classify #(.DATA_W(DATA_W)) u_classify (
    .code_i (sample_i),
    .gain_i (gain_q),
    .bin_o  (bin)
  );

  cal_xover_tally #(.CNT_W(CNT_W)) u_tally (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (take),
    .bin_i  (bin),
    .cnt_o  (cnt)
  );

  cal_xover_judge #(.CNT_W(CNT_W)) u_judge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_i      (cnt),
    .res_vld_i  (res_vld),
    .tol_i      (tol_q),
    .balanced_o (balanced_o),
    .dir_o      (dir)
  );

  assign lo_cnt_o  = cnt[BIN_LO];
  assign hi_cnt_o  = cnt[BIN_HI];
  assign out_cnt_o = cnt[BIN_BELOW] + cnt[BIN_ABOVE];
  assign dir_o     = dir;

  logic [CNT_W+1:0] total, expect_len;
  assign total      = (CNT_W+2)'(cnt[BIN_LO]) + (CNT_W+2)'(cnt[BIN_HI]) +
                      (CNT_W+2)'(cnt[BIN_BELOW]) + (CNT_W+2)'(cnt[BIN_ABOVE]);
  assign expect_len = (len_q == '0) ? (CNT_W+2)'(1) : (CNT_W+2)'(len_q);

  // R4: window closes with exactly the requested number of samples counted
  a_r4_window_total: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (total == expect_len));
endmodule

// File: tb/cal_xover_mon_tb.sv
module cal_xover_mon_tb;
  import cal_xover_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [13:0] sample_i = '0;
  logic        valid_i = 1'b0;
  logic        gain_mode_i = 1'b0;
  logic [15:0] win_len_i = '0;
  logic [15:0] tol_i = '0;
  logic        start_i = 1'b0;
  logic [15:0] lo_cnt_o, hi_cnt_o, out_cnt_o;
  logic        balanced_o, done_o, offset_ok_o;
  logic [2:0]  dir_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_xover_mon u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample_i), .valid_i(valid_i),
    .gain_mode_i(gain_mode_i), .win_len_i(win_len_i), .tol_i(tol_i),
    .start_i(start_i), .lo_cnt_o(lo_cnt_o), .hi_cnt_o(hi_cnt_o),
    .out_cnt_o(out_cnt_o), .balanced_o(balanced_o), .dir_o(dir_o),
    .done_o(done_o), .offset_ok_o(offset_ok_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic start_win(input bit gain, input int len, input int tol);
    start_i = 1'b1; gain_mode_i = gain; win_len_i = 16'(len); tol_i = 16'(tol);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic push(input logic [13:0] code, input int gap);
    sample_i = code; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    sample_i = 14'h1555;
    repeat (gap) @(negedge clk);
  endtask

  task automatic expect_end(input string req, input int lo, input int hi, input int out,
                            input int bal, input int dir);
    chk_eq("R5", {req, " done pulse"}, int'(done_o), 1);
    chk_eq(req, "lo count", int'(lo_cnt_o), lo);
    chk_eq(req, "hi count", int'(hi_cnt_o), hi);
    chk_eq(req, "out count", int'(out_cnt_o), out);
    chk_eq("R7", {req, " balanced"}, int'(balanced_o), bal);
    chk_eq("R8", {req, " dir"}, int'(dir_o), dir);
    @(negedge clk);
    chk_eq("R5", {req, " done drops"}, int'(done_o), 0);
    chk_eq("R6", {req, " lo held"}, int'(lo_cnt_o), lo);
    chk_eq("R6", {req, " dir held"}, int'(dir_o), dir);
  endtask

  task automatic t_reset();
    chk_eq("R1", "lo", int'(lo_cnt_o), 0);
    chk_eq("R1", "hi", int'(hi_cnt_o), 0);
    chk_eq("R1", "out", int'(out_cnt_o), 0);
    chk_eq("R1", "done", int'(done_o), 0);
    chk_eq("R1", "balanced", int'(balanced_o), 0);
    chk_eq("R1", "dir", int'(dir_o), 0);
    chk_eq("R1", "offset_ok", int'(offset_ok_o), 0);
  endtask

  task automatic t_gain_refused_reset();
    start_win(1'b1, 2, 0);
    push(14'h3FFE, 0);
    chk_eq("R9", "done after refused start", int'(done_o), 0);
    push(14'h3FFF, 1);
    chk_eq("R9", "hi after refused start", int'(hi_cnt_o), 0);
    chk_eq("R9", "dir after refused start", int'(dir_o), int'(DIR_NONE));
  endtask

  task automatic t_offset_low_dominant();
    start_win(1'b0, 6, 1);
    push(14'h2000, 2); push(14'h2001, 0); push(14'h2000, 1);
    push(14'h2000, 0); push(14'h2001, 3); push(14'h2000, 0);
    expect_end("R2", 4, 2, 0, 0, int'(DIR_LOW));
    chk_eq("R9", "offset_ok after unbalanced", int'(offset_ok_o), 0);
  endtask

  task automatic t_gain_refused_held();
    start_win(1'b1, 1, 0);
    push(14'h3FFF, 0);
    chk_eq("R9", "no done when refused", int'(done_o), 0);
    chk_eq("R9", "lo kept", int'(lo_cnt_o), 4);
    chk_eq("R9", "hi kept", int'(hi_cnt_o), 2);
  endtask

  task automatic t_outside_below();
    start_win(1'b0, 3, 5);
    push(14'h1FF0, 0); push(14'h0000, 1); push(14'h2000, 0);
    expect_end("R3", 1, 0, 2, 0, int'(DIR_BELOW));
  endtask

  task automatic t_outside_above();
    start_win(1'b0, 3, 5);
    push(14'h2002, 0); push(14'h3FFF, 0); push(14'h2001, 0);
    expect_end("R3", 0, 1, 2, 0, int'(DIR_ABOVE));
  endtask

  task automatic t_restart_balanced();
    start_win(1'b0, 4, 0);
    push(14'h2000, 0); push(14'h2000, 0);
    start_win(1'b0, 4, 0);
    chk_eq("R6", "lo cleared on restart", int'(lo_cnt_o), 0);
    chk_eq("R6", "dir cleared on restart", int'(dir_o), int'(DIR_NONE));
    push(14'h2000, 0); push(14'h2001, 0); push(14'h2000, 0); push(14'h2001, 0);
    expect_end("R6", 2, 2, 0, 1, int'(DIR_EVEN));
    chk_eq("R9", "offset_ok after balanced", int'(offset_ok_o), 1);
  endtask

  task automatic t_start_sample_dropped();
    start_i = 1'b1; gain_mode_i = 1'b0; win_len_i = 16'd2; tol_i = 16'd0;
    sample_i = 14'h2005; valid_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; valid_i = 1'b0;
    push(14'h2000, 0); push(14'h2001, 0);
    expect_end("R4", 1, 1, 0, 1, int'(DIR_EVEN));
  endtask

  task automatic t_gain_windows();
    start_win(1'b1, 6, 1);
    push(14'h3FFE, 0); push(14'h3FFF, 0); push(14'h3FFF, 1);
    push(14'h3FFE, 0); push(14'h3FFF, 0); push(14'h3FFF, 0);
    expect_end("R3", 2, 4, 0, 0, int'(DIR_HIGH));
    start_win(1'b1, 6, 2);
    push(14'h3FFE, 0); push(14'h3FFF, 0); push(14'h3FFF, 0);
    push(14'h3FFE, 0); push(14'h3FFF, 0); push(14'h3FFF, 0);
    expect_end("R7", 2, 4, 0, 1, int'(DIR_HIGH));
    start_win(1'b1, 2, 3);
    push(14'h3FFD, 0); push(14'h3FFE, 0);
    expect_end("R3", 1, 0, 1, 0, int'(DIR_BELOW));
    chk_eq("R9", "gain window keeps offset_ok", int'(offset_ok_o), 1);
  endtask

  task automatic t_zero_len_revoke();
    start_win(1'b0, 0, 0);
    push(14'h2000, 0);
    expect_end("R4", 1, 0, 0, 0, int'(DIR_LOW));
    chk_eq("R9", "offset_ok revoked", int'(offset_ok_o), 0);
    start_win(1'b1, 1, 0);
    push(14'h3FFE, 0);
    chk_eq("R9", "gain refused after revoke", int'(done_o), 0);
    chk_eq("R9", "lo kept after revoke", int'(lo_cnt_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_gain_refused_reset();
    t_offset_low_dominant();
    t_gain_refused_held();
    t_outside_below();
    t_outside_above();
    t_restart_balanced();
    t_start_sample_dropped();
    t_gain_windows();
    t_zero_len_revoke();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule